// File: doc/BRIEF.md
# Pipelined Fifth Power Unit

This block raises an unsigned operand to the fifth power in a chain of registered multiply steps. A consumer may offer a fresh operand on every clock cycle. Each result comes out a fixed four cycles after its operand was taken, together with a flag that marks it as meaningful. The result is five times as wide as the operand, so the exact value always fits.

Internally, a capture register is followed by three multiply stages: squaring, squaring the square, and a final multiply by the delayed operand. The operand itself travels through a delay line so that it meets the fourth power in the last stage. A one-bit qualifier shifts alongside the data. Only this qualifier is reset.

Top module: `pow5_pipe`

## Requirements
- R1: When `out_vld` is high, `out_pow` equals the operand taken four cycles earlier raised to the fifth power, computed exactly in 5*N bits.
- R2: `out_vld` goes high exactly four rising clock edges after the edge that sampled `in_vld` high.
- R3: An operand offered with `in_vld` low produces no output: `out_vld` is low four edges later, whatever `in_op` held.
- R4: Operands offered on consecutive cycles give results on consecutive cycles, in the same order, with none lost.
- R5: Driving `rst_n` low clears `out_vld` at once, without waiting for a clock edge, including while results are in flight.
- R6: After `rst_n` is released, `out_vld` stays low until the first operand accepted after the release has passed through all four stages.
- R7: Operands zero, one and the all-ones value give 0, 1 and (2^N-1)^5 respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; clears the valid chain |
| in_vld | input | 1 | High when `in_op` carries an operand to process |
| in_op | input | N | Unsigned operand |
| out_vld | output | 1 | High when `out_pow` holds a result |
| out_pow | output | 5*N | Fifth power of the operand taken four cycles earlier |

## Verification
The properties assume that `in_vld` is low while `rst_n` is low and that reset is released away from a rising edge, so no half-accepted operand enters the chain. The stimulus drives inputs only on falling edges, keeps `in_vld` low whenever no operand is offered (including every idle cycle and every reset period), and lifts `rst_n` on a falling edge. Operands span zero, one, the all-ones value, long back-to-back bursts, bubbles carrying garbage operands, and an asynchronous reset with valid results still in the stages.

// File: rtl/pow5_pkg.sv
`timescale 1ns/1ps
package pow5_pkg;

    // Number of register stages between operand and result.
    localparam int unsigned POW5_LATENCY = 4;

    // Exponent built by the stage chain: (n^2)^2 * n.
    localparam int unsigned POW5_EXP = 5;

endpackage

// File: rtl/pow5_mul_stage.sv
`timescale 1ns/1ps
// One registered multiply: prod is a*b, one cycle after a and b.
module pow5_mul_stage #(
    parameter int unsigned WA = 8,
    parameter int unsigned WB = 8
) (
    input  logic                clk,
    input  logic [WA-1:0]       a,
    input  logic [WB-1:0]       b,
    output logic [WA+WB-1:0]    prod
);
    localparam int unsigned WP = WA + WB;

    logic [WP-1:0] a_x;
    logic [WP-1:0] b_x;
    logic [WP-1:0] prod_d;
    logic [WP-1:0] prod_q;

    always_comb begin
        a_x    = WP'(a);
        b_x    = WP'(b);
        prod_d = a_x * b_x;
    end

    // Data path register: no reset needed, qualified by the valid chain.
    always_ff @(posedge clk) begin
        prod_q <= prod_d;
    end

    assign prod = prod_q;

endmodule

// File: rtl/pow5_delay.sv
`timescale 1ns/1ps
// Plain data delay line of DEPTH registers, no reset.
module pow5_delay #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 2
) (
    input  logic         clk,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] tap_d [DEPTH];
    logic [W-1:0] tap_q [DEPTH];

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_tap
            if (gi == 0) begin : g_head
                always_comb tap_d[gi] = din;
            end else begin : g_body
                always_comb tap_d[gi] = tap_q[gi-1];
            end
            always_ff @(posedge clk) begin
                tap_q[gi] <= tap_d[gi];
            end
        end
    endgenerate

    assign dout = tap_q[DEPTH-1];

endmodule

// File: rtl/pow5_valid_pipe.sv
`timescale 1ns/1ps
// Valid qualifier shift chain with asynchronous active-low clear.
module pow5_valid_pipe #(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vin,
    output logic vout
);
    logic [DEPTH-1:0] vld_d;
    logic [DEPTH-1:0] vld_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_comb vld_d = vin;
        end else begin : g_chain
            always_comb vld_d = {vld_q[DEPTH-2:0], vin};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_d;
        end
    end

    assign vout = vld_q[DEPTH-1];

endmodule

// File: rtl/pow5_pipe.sv
`timescale 1ns/1ps
// Fully pipelined n^5: capture, square, fourth power, fifth power.
module pow5_pipe
    import pow5_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_vld,
    input  logic [N-1:0]   in_op,
    output logic           out_vld,
    output logic [5*N-1:0] out_pow
);
    localparam int unsigned W2 = 2 * N;
    localparam int unsigned W4 = 4 * N;
    localparam int unsigned W5 = W4 + N;
    // Operand must wait through the square and fourth-power stages.
    localparam int unsigned OP_WAIT = POW5_LATENCY - 2;

    typedef struct packed {
        logic [N-1:0] op;
    } cap_t;

    cap_t          cap_d;
    cap_t          cap_q;
    logic [W2-1:0] sq;
    logic [W4-1:0] p4;
    logic [N-1:0]  op_late;
    logic [W5-1:0] p5;

    // Stage 1: capture operand.
    always_comb begin
        cap_d    = cap_q;
        cap_d.op = in_op;
    end

    always_ff @(posedge clk) begin
        cap_q <= cap_d;
    end

    // Stage 2: n^2
    pow5_mul_stage #(.WA(N), .WB(N)) u_sq (
        .clk  (clk),
        .a    (cap_q.op),
        .b    (cap_q.op),
        .prod (sq)
    );

    // Operand delayed to line up with n^4.
    pow5_delay #(.W(N), .DEPTH(OP_WAIT)) u_opd (
        .clk  (clk),
        .din  (cap_q.op),
        .dout (op_late)
    );

    // Stage 3: n^4 = (n^2)^2
    pow5_mul_stage #(.WA(W2), .WB(W2)) u_p4 (
        .clk  (clk),
        .a    (sq),
        .b    (sq),
        .prod (p4)
    );

    // Stage 4: n^5 = n^4 * n
    pow5_mul_stage #(.WA(W4), .WB(N)) u_p5 (
        .clk  (clk),
        .a    (p4),
        .b    (op_late),
        .prod (p5)
    );

    pow5_valid_pipe #(.DEPTH(POW5_LATENCY)) u_vld (
        .clk   (clk),
        .rst_n (rst_n),
        .vin   (in_vld),
        .vout  (out_vld)
    );

    assign out_pow = p5;

endmodule

// File: rtl/pow5_chk.sv
`timescale 1ns/1ps
module pow5_chk #(
    parameter int unsigned N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_vld,
    input logic [N-1:0]   in_op,
    input logic           out_vld,
    input logic [5*N-1:0] out_pow
);
    localparam int unsigned WR = 5 * N;

    function automatic logic [WR-1:0] ref_pow5(input logic [N-1:0] x);
        logic [WR-1:0] acc;
        acc = WR'(1);
        for (int k = 0; k < 5; k++) acc = acc * WR'(x);
        return acc;
    endfunction

    // Edges seen since reset release, saturating at 4.
    logic [2:0] cyc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc_q <= '0;
        else if (cyc_q != 3'd4) cyc_q <= cyc_q + 3'd1;
    end

    // R1
    value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 3'd4 && out_vld) |-> out_pow == ref_pow5($past(in_op, 4)));

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == 3'd4) |-> out_vld == $past(in_vld, 4));

    // R5
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> !out_vld);

    // R6
    startup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q < 3'd4) |-> !out_vld);

endmodule

bind pow5_pipe pow5_chk #(.N(N)) u_pow5_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_op   (in_op),
    .out_vld (out_vld),
    .out_pow (out_pow)
);

// File: tb/tb_pow5_pipe.sv
`timescale 1ns/1ps
module tb_pow5_pipe;
    localparam int unsigned N  = 8;
    localparam int unsigned WR = 5 * N;

    logic          clk;
    logic          rst_n;
    logic          in_vld;
    logic [N-1:0]  in_op;
    logic          out_vld;
    logic [WR-1:0] out_pow;

    int checks = 0;
    int fails  = 0;
    int edge_cnt = 0;
    bit done = 0;

    typedef struct {
        logic         v;
        logic [N-1:0] op;
        int           due;
    } item_t;
    item_t sb[$];

    pow5_pipe #(.N(N)) dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
        .out_vld(out_vld), .out_pow(out_pow)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic logic [WR-1:0] pow5_exp(input logic [N-1:0] x);
        logic [WR-1:0] r;
        r = WR'(1);
        for (int k = 0; k < 5; k++) r = r * WR'(x);
        return r;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [WR-1:0] act, input logic [WR-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic v, input logic [N-1:0] op);
        @(negedge clk);
        in_vld = v;
        in_op  = op;
        sb.push_back('{v, op, edge_cnt + 4});
    endtask

    // Monitor: compare outputs just after each rising edge.
    initial begin
        logic prev_v;
        prev_v = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            edge_cnt++;
            if (rst_n) begin
                if (sb.size() > 0 && sb[0].due == edge_cnt) begin
                    item_t it;
                    it = sb.pop_front();
                    if (it.v) begin
                        string tag;
                        if (it.op == '0 || it.op == '1 || it.op == N'(1)) tag = "R7";
                        else if (prev_v) tag = "R4";
                        else tag = "R1";
                        check(out_vld == 1'b1, "R2", WR'(out_vld), WR'(1));
                        check(out_pow == pow5_exp(it.op), tag, out_pow, pow5_exp(it.op));
                    end else begin
                        check(out_vld == 1'b0, "R3", WR'(out_vld), WR'(0));
                    end
                    prev_v = it.v;
                end else begin
                    // Nothing accepted four edges ago (post-reset fill).
                    check(out_vld == 1'b0, "R6", WR'(out_vld), WR'(0));
                    prev_v = 1'b0;
                end
            end else begin
                prev_v = 1'b0;
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL R4 watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n  = 1'b0;
        in_vld = 1'b0;
        in_op  = '0;
        #1;
        check(out_vld == 1'b0, "R5", WR'(out_vld), WR'(0));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Boundary operands back to back.
        drive(1'b1, '0);
        drive(1'b1, N'(1));
        drive(1'b1, '1);
        drive(1'b1, N'(2));
        drive(1'b1, N'(3));
        drive(1'b1, '1);
        drive(1'b0, '0);

        // Long back-to-back burst.
        for (int i = 0; i < 40; i++) drive(1'b1, N'($urandom));

        // Bubbles carrying garbage operands.
        for (int i = 0; i < 20; i++) drive(i[0], N'($urandom));

        // Random mix of valid and idle cycles.
        for (int i = 0; i < 60; i++) drive(($urandom % 3) != 0, N'($urandom));

        // Asynchronous reset with results in flight.
        for (int i = 0; i < 6; i++) drive(1'b1, N'($urandom));
        #1;
        rst_n  = 1'b0;
        in_vld = 1'b0;
        sb.delete();
        #0.5;
        check(out_vld == 1'b0, "R5", WR'(out_vld), WR'(0));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 20; i++) drive(1'b1, N'($urandom));
        for (int i = 0; i < 8; i++) drive(1'b0, N'($urandom));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule